// File: doc/BRIEF.md
# Shared-Estimator Probabilistic Flow Counter

This block keeps approximate packet counts for many flows at low storage cost. A flow does not hold a full-width count. It holds only a short pointer into one estimate table that all flows share. The table's values rise strictly from zero, and the count reported for a flow is the table entry that its pointer selects. Because the table can be spread out, a pointer of a few bits can stand for counts in the millions. The precision falls as the count grows.

A host fills the table through a write port. For each entry the host gives the estimate value and an advance probability, written as a fixed-point fraction of 2^PROB_W. For entry p the host sets this probability to the reciprocal of the gap to entry p+1. The block does not derive it. Each packet-arrival event names a flow. The block reads that flow's pointer and compares the entry's probability with a pseudo-random word taken from an LFSR. When the random word is the smaller of the two, the pointer moves up by one, so the expected reported count tracks the true count.

Events pass through a two-stage read-modify-write pipeline. Stage 1 captures the pointer and stage 2 decides the step and writes it back. The stage-2 result is forwarded into stage 1, so events to one flow may arrive on consecutive cycles and each one counts. A combinational read port gives the pointer and the estimate of any flow.

Top module: `approx_flow_counter`

## Requirements
- R1: After reset, every flow's pointer is 0, and `rd_ptr` reads 0 for every flow.
- R2: `rd_est` equals the estimate value held in the table entry indexed by the pointer of flow `rd_flow`, and `rd_ptr` shows that pointer.
- R3: When an event meets an entry whose probability field equals 2^PROB_W, the flow's pointer rises by exactly one. The new value reads back after the second rising edge after the event is presented.
- R4: When an event meets an entry whose probability field is 0, the flow's pointer stays unchanged.
- R5: A pointer at the last entry (2^PTR_W − 1) never advances. `sat_hit` is high during the cycle after such an event is captured.
- R6: Events to the same flow on consecutive cycles all take effect. N certain back-to-back events raise that pointer by N.
- R7: An event changes only the pointer of the flow it names.
- R8: A table write leaves every stored pointer unchanged. `rd_est` shows the new value of the entry that was written.
- R9: For a probability field of 2^(PROB_W−1), about half of the events advance the pointer. Over 400 events the count of advances lies between 150 and 250.
- R10: While `ev_valid` is low, no pointer changes, whatever the value of `ev_flow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | PTR_W | Table entry to write |
| tbl_est | input | EST_W | Estimate value for the entry |
| tbl_prob | input | PROB_W+1 | Advance probability as a fraction of 2^PROB_W |
| ev_valid | input | 1 | Packet-arrival event present |
| ev_flow | input | FLOW_W | Flow named by the event |
| rd_flow | input | FLOW_W | Flow to read |
| rd_ptr | output | PTR_W | Pointer of `rd_flow` |
| rd_est | output | EST_W | Estimate of `rd_flow` |
| sat_hit | output | 1 | An event in stage 2 met a saturated pointer |

## Verification
Two functions can fall in one cycle: the write-back of one event and the pointer read for the next event to the same flow. The bench provokes this by sending bursts of events to one flow on consecutive cycles. Each burst runs with certain probability, and one burst runs long enough to reach saturation. A lost or doubled step shows up as a pointer that differs from the bench's model, which adds the burst length and stops at the top entry.

// File: rtl/approx_flow_counter.sv
module approx_flow_counter #(
  parameter int          FLOW_W = 6,
  parameter int          PTR_W  = 8,
  parameter int          EST_W  = 32,
  parameter int          PROB_W = 16,
  parameter logic [31:0] SEED   = 32'h1ACE_B00C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [PTR_W-1:0]  tbl_idx,
  input  logic [EST_W-1:0]  tbl_est,
  input  logic [PROB_W:0]   tbl_prob,
  input  logic              ev_valid,
  input  logic [FLOW_W-1:0] ev_flow,
  input  logic [FLOW_W-1:0] rd_flow,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [EST_W-1:0]  rd_est,
  output logic              sat_hit
);
  localparam int NFLOW = 1 << FLOW_W;
  localparam int NENT  = 1 << PTR_W;
  localparam logic [PTR_W-1:0] PMAX = PTR_W'(NENT - 1);

  logic [EST_W-1:0]  est_mem  [NENT];
  logic [PROB_W:0]   prob_mem [NENT];
  logic [PTR_W-1:0]  ptr_mem  [NFLOW];

  logic              s1_valid;
  logic [FLOW_W-1:0] s1_flow;
  logic [PTR_W-1:0]  s1_ptr;
  logic [31:0]       lfsr;

  always_ff @(posedge clk)
    if (tbl_we) begin
      est_mem[tbl_idx]  <= tbl_est;
      prob_mem[tbl_idx] <= tbl_prob;
    end

  always_ff @(posedge clk)
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= (lfsr >> 1) ^ (lfsr[0] ? 32'hA300_0000 : 32'h0);

  wire [PROB_W-1:0] rnd    = lfsr[PROB_W-1:0];
  wire [PROB_W:0]   prob_at = prob_mem[s1_ptr];
  wire              at_top = (s1_ptr == PMAX);
  wire              adv    = s1_valid && !at_top && ({1'b0, rnd} < prob_at);
  wire [PTR_W-1:0]  s1_next = s1_ptr + PTR_W'(adv);
  wire              fwd    = s1_valid && (s1_flow == ev_flow);
  wire [PTR_W-1:0]  ev_ptr = fwd ? s1_next : ptr_mem[ev_flow];

  always_ff @(posedge clk)
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_flow  <= '0;
      s1_ptr   <= '0;
      for (int i = 0; i < NFLOW; i++) ptr_mem[i] <= '0;
    end else begin
      s1_valid <= ev_valid;
      if (ev_valid) begin
        s1_flow <= ev_flow;
        s1_ptr  <= ev_ptr;
      end
      if (s1_valid) ptr_mem[s1_flow] <= s1_next;
    end

  assign sat_hit = s1_valid && at_top;
  assign rd_ptr  = ptr_mem[rd_flow];
  assign rd_est  = est_mem[rd_ptr];

  p_step_le_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (ptr_mem[$past(s1_flow)] == $past(s1_ptr)) ||
                 (ptr_mem[$past(s1_flow)] == $past(s1_ptr) + 1'b1));

  p_zero_prob_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && prob_at == '0) |=> ptr_mem[$past(s1_flow)] == $past(s1_ptr));

  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_ptr == PMAX) |=> ptr_mem[$past(s1_flow)] == PMAX);

  p_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && ev_valid && ev_flow == s1_flow) |=> s1_ptr == ptr_mem[s1_flow]);
endmodule

// File: tb/approx_flow_counter_tb.sv
module approx_flow_counter_tb;
  localparam int CLK_P  = 10;
  localparam int FLOW_W = 6;
  localparam int PTR_W  = 8;
  localparam int EST_W  = 32;
  localparam int PROB_W = 16;
  localparam int NFLOW  = 1 << FLOW_W;
  localparam int NENT   = 1 << PTR_W;
  localparam logic [PROB_W:0] P_ONE  = (PROB_W+1)'(1) << PROB_W;
  localparam logic [PROB_W:0] P_HALF = (PROB_W+1)'(1) << (PROB_W-1);
  localparam int NV = 7;
  localparam int VF [NV] = '{3, 3, 7, 3, 0, 63, 7};
  localparam int VN [NV] = '{1, 4, 10, 2, 0, 1, 3};

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0;
  logic [PTR_W-1:0] tbl_idx = '0;
  logic [EST_W-1:0] tbl_est = '0;
  logic [PROB_W:0] tbl_prob = '0;
  logic ev_valid = 0;
  logic [FLOW_W-1:0] ev_flow = '0, rd_flow = '0;
  logic [PTR_W-1:0] rd_ptr;
  logic [EST_W-1:0] rd_est;
  logic sat_hit;
  int checks = 0, fails = 0;
  int model [NFLOW];

  always #(CLK_P/2) clk = ~clk;

  approx_flow_counter #(.FLOW_W(FLOW_W), .PTR_W(PTR_W), .EST_W(EST_W), .PROB_W(PROB_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_est(tbl_est),
    .tbl_prob(tbl_prob), .ev_valid(ev_valid), .ev_flow(ev_flow), .rd_flow(rd_flow),
    .rd_ptr(rd_ptr), .rd_est(rd_est), .sat_hit(sat_hit));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input int idx, input int est, input logic [PROB_W:0] pr);
    @(negedge clk);
    tbl_we = 1; tbl_idx = PTR_W'(idx); tbl_est = EST_W'(est); tbl_prob = pr;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send(input int fl, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ev_valid = 1; ev_flow = FLOW_W'(fl);
    end
    @(negedge clk);
    ev_valid = 0;
    @(negedge clk);
  endtask

  task automatic rd_check(input int fl, input string req);
    rd_flow = FLOW_W'(fl);
    #1;
    check(rd_ptr == PTR_W'(model[fl]), req, rd_ptr, model[fl]);
    check(rd_est == EST_W'(5 * model[fl]), "R2", rd_est, 5 * model[fl]);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NFLOW; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NENT; i++) wr_tbl(i, 5 * i, P_ONE);

    // R1: reset state of all flows
    begin
      int bad = 0;
      for (int f = 0; f < NFLOW; f++) begin
        rd_flow = FLOW_W'(f); #1;
        if (rd_ptr != 0 || rd_est != 0) bad++;
      end
      check(bad == 0, "R1", bad, 0);
    end

    // R3 R6 R7: vector walk with certain probability
    for (int v = 0; v < NV; v++) begin
      send(VF[v], VN[v]);
      model[VF[v]] += VN[v];
      for (int f = 0; f < NFLOW; f += 1) begin
        if (f == VF[v] || f == 3 || f == 7 || f == 0 || f == 63) rd_check(f, "R6/R7");
      end
    end
    rd_check(5, "R7");

    // R10: idle with changing ev_flow
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); ev_valid = 0; ev_flow = FLOW_W'(k);
    end
    @(negedge clk);
    rd_check(3, "R10"); rd_check(7, "R10");

    // R4: zero probability at flow 3's entry
    wr_tbl(model[3], 5 * model[3], '0);
    send(3, 20);
    rd_check(3, "R4");
    wr_tbl(model[3], 5 * model[3], P_ONE);

    // R8: table write leaves pointers unchanged
    wr_tbl(model[7], 999, P_ONE);
    rd_flow = 7; #1;
    check(rd_ptr == PTR_W'(model[7]), "R8", rd_ptr, model[7]);
    check(rd_est == 999, "R8", rd_est, 999);
    wr_tbl(model[7], 5 * model[7], P_ONE);
    rd_check(3, "R8");

    // R5: saturation on flow 10
    send(10, NENT - 1);
    model[10] = NENT - 1;
    rd_check(10, "R5");
    @(negedge clk); ev_valid = 1; ev_flow = 10;
    @(negedge clk); ev_valid = 0;
    check(sat_hit == 1, "R5", sat_hit, 1);
    @(negedge clk);
    check(sat_hit == 0, "R5", sat_hit, 0);
    rd_check(10, "R5");

    // R9: half probability statistics on flow 20
    for (int i = 0; i < NENT - 1; i++) wr_tbl(i, 5 * i, P_HALF);
    send(20, 400);
    rd_flow = 20; #1;
    check(rd_ptr >= 150 && rd_ptr <= 250, "R9", rd_ptr, 200);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule